// File: doc/BRIEF.md
# Per-Link Interrupt Status Controller

This block gathers interrupt-worthy events for a four-link, four-group inverse-multiplexing receiver and turns them into one interrupt line. Each link owns an 8-bit sticky status register and an 8-bit enable register. A separate summary register holds one overflow flag per group. Link monitors, ICP-cell logic and counter logic present single-cycle event pulses. The block latches these pulses and keeps them until they are cleared.

The status bits do not all clear the same way. Alarm and cell-event bits clear when software writes a zero to them. The counter overflow bit and the group overflow flags clear only when their source is serviced, which a per-source service pulse signals. Only link 0's register carries two summary bits: a live "any group overflow" bit and a sticky transmit/frame event bit. The interrupt output is high while any status bit is set together with its enable bit.

Software reaches the registers through a plain access port. A write takes effect at the clock edge that samples it. A read returns its data one cycle later, marked by a one-cycle valid strobe. The port never stalls, so it needs no ready or back-pressure signal: every request is accepted in the cycle it is presented.

Top module: `link_irq_ctrl`

## Requirements
- R1: After reset, every status, enable and group overflow register reads 0x00 and `irq` is low.
- R2: A pulse on `lnk_icp_chg`, `lnk_icp_viol`, `lnk_lods`, `lnk_lif` or `lnk_lcd` sets status bit 5, 4, 3, 2 or 1 of that link. The bit stays set until software writes that status register with a 0 in the bit position. Writing a 1 leaves the bit unchanged.
- R3: A pulse on `lnk_cnt_ovf` sets status bit 0 of that link. Writes do not affect the bit. It clears only on a `lnk_cnt_svc` pulse for that link.
- R4: Status bit 6 of link 0 sets on a pulse of any bit of `grp_tx_done` or `grp_frame`. It clears when software writes a 0 to it. For links 1 to 3, bits 7 and 6 always read 0.
- R5: Group overflow register bit g (for g from 0 to 3) sets on a `grp_ovf_set[g]` pulse and clears only on a `grp_ovf_svc[g]` pulse. Bits 7:4 read 0, and writes to this register are ignored.
- R6: Status bit 7 of link 0 reads 1 exactly while any group overflow bit is set.
- R7: If a set event and a clear (a zero-write or a service pulse) reach the same bit in the same cycle, the bit ends up set.
- R8: Each enable register holds all 8 written bits and reads them back.
- R9: `irq` is high exactly when, for some link, a status bit and the enable bit at the same position are both 1.
- R10: A read request returns its data on `rsp_rdata` with `rsp_valid` high in the following cycle. An address that maps to no register reads 0x00. Status registers are at 0x222+link, enable registers at 0x219+link, and the group overflow register is at 0x235.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Register write strobe |
| req_rd | input | 1 | Register read strobe |
| req_addr | input | 12 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid |
| rsp_valid | output | 1 | Read data valid, one cycle after req_rd |
| lnk_icp_chg | input | 4 | Per link: ICP cell with changes received |
| lnk_icp_viol | input | 4 | Per link: ICP cell violation received |
| lnk_lods | input | 4 | Per link: out of delay synchronization |
| lnk_lif | input | 4 | Per link: loss of IMA frame |
| lnk_lcd | input | 4 | Per link: loss of cell delineation |
| lnk_cnt_ovf | input | 4 | Per link: counter overflow event |
| lnk_cnt_svc | input | 4 | Per link: overflowed counters serviced |
| grp_tx_done | input | 4 | Per group: transmit ICP ready flag returned to 1 |
| grp_frame | input | 4 | Per group: frame pulse detected |
| grp_ovf_set | input | 4 | Per group: counter or receive FIFO overflow |
| grp_ovf_svc | input | 4 | Per group: overflow source serviced |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the same-cycle collisions first. An event that arrives together with a zero-write, or a counter overflow that arrives together with its service pulse, must leave the bit set; a design that lets the clear win would drop the event silently. It writes all ones and all zeros to the source-cleared bits and to the group register. A design that treats those bits as write-zero-to-clear would lose the counter and overflow flags early. It also reads the summary bits from links 1 to 3, where a decoding slip would copy link 0's bits 7 and 6 into the wrong registers. Finally, it checks the interrupt line both with a status bit set and its enable clear and with the enable set, so that a missing enable mask would show as an interrupt that never goes low.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int REG_W = 8;

  // status bit positions (link 0 summary bits at the top)
  localparam int B_GOVF    = 7;
  localparam int B_TXEV    = 6;
  localparam int B_ICPCHG  = 5;
  localparam int B_ICPVIOL = 4;
  localparam int B_LODS    = 3;
  localparam int B_LIF     = 2;
  localparam int B_LCD     = 1;
  localparam int B_CNTOVF  = 0;

  typedef struct packed {
    logic icp_chg;
    logic icp_viol;
    logic lods;
    logic lif;
    logic lcd;
  } link_evt_t;
endpackage

// File: rtl/lic_grp_ovf.sv
module lic_grp_ovf
  import lic_pkg::*;
#(
  parameter int NUM_GROUPS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] ovf_set,
  input  logic [NUM_GROUPS-1:0] ovf_svc,
  output logic [REG_W-1:0]      grp_byte,
  output logic                  any_ovf
);
  localparam int PAD = REG_W - NUM_GROUPS;

  logic [NUM_GROUPS-1:0] flags;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~ovf_svc) | ovf_set;
  end

  generate
    if (PAD > 0) begin : g_pad
      assign grp_byte = {{PAD{1'b0}}, flags};
    end else begin : g_nopad
      assign grp_byte = flags[REG_W-1:0];
    end
  endgenerate

  assign any_ovf = |flags;

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_chk
      // R5: a set flag stays set until serviced; R7: set beats service
      assert_grp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[g] && !ovf_svc[g]) |=> flags[g]);
      assert_grp_setwins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set[g] |=> flags[g]);
    end
  endgenerate
endmodule

// File: rtl/lic_link_reg.sv
module lic_link_reg
  import lic_pkg::*;
#(
  parameter bit HAS_SUMMARY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  link_evt_t        evt,
  input  logic             tx_evt,
  input  logic             grp_any,
  input  logic             cnt_set,
  input  logic             cnt_svc,
  input  logic             sts_wr,
  input  logic             en_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] sts,
  output logic [REG_W-1:0] en
);
  // bits cleared by a zero-write; bit 6 only where the summary exists
  localparam logic [REG_W-1:0] W0C_MASK = HAS_SUMMARY ? 8'h7E : 8'h3E;

  logic [REG_W-2:0] held;
  logic [REG_W-2:0] set_vec;
  logic [REG_W-2:0] clr_vec;
  logic             tx_gated;
  logic             govf_gated;

  assign tx_gated   = tx_evt  & HAS_SUMMARY;
  assign govf_gated = grp_any & HAS_SUMMARY;

  always_comb begin
    set_vec           = '0;
    set_vec[B_TXEV]   = tx_gated;
    set_vec[B_ICPCHG] = evt.icp_chg;
    set_vec[B_ICPVIOL]= evt.icp_viol;
    set_vec[B_LODS]   = evt.lods;
    set_vec[B_LIF]    = evt.lif;
    set_vec[B_LCD]    = evt.lcd;
    set_vec[B_CNTOVF] = cnt_set;
  end

  always_comb begin
    clr_vec           = {(REG_W-1){sts_wr}} & ~wdata[REG_W-2:0] & W0C_MASK[REG_W-2:0];
    clr_vec[B_CNTOVF] = cnt_svc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= '0;
      en   <= '0;
    end else begin
      held <= (held & ~clr_vec) | set_vec;
      if (en_wr) en <= wdata;
    end
  end

  assign sts = {govf_gated, held};

  // R2: a sticky bit survives a cycle without event or zero-write
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[B_LODS] && !(sts_wr && !wdata[B_LODS])) |=> sts[B_LODS]);
  // R3: counter bit ignores writes, held until serviced
  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[B_CNTOVF] && !cnt_svc) |=> sts[B_CNTOVF]);
  // R7: an event is never lost to a same-cycle clear
  assert_setwins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.lif && sts_wr && !wdata[B_LIF]) |=> sts[B_LIF]);
  // R4: links without the summary never show bits 7:6
  assert_nosum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_SUMMARY |-> (sts[B_GOVF] == 1'b0 && sts[B_TXEV] == 1'b0));
endmodule

// File: rtl/lic_reg_port.sv
module lic_reg_port
  import lic_pkg::*;
#(
  parameter int          NUM_LINKS = 4,
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] STS_BASE  = 12'h222,
  parameter logic [11:0] EN_BASE   = 12'h219,
  parameter logic [11:0] GRP_ADDR  = 12'h235
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_wr,
  input  logic                       req_rd,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [NUM_LINKS*REG_W-1:0] sts_flat,
  input  logic [NUM_LINKS*REG_W-1:0] en_flat,
  input  logic [REG_W-1:0]           grp_byte,
  output logic [NUM_LINKS-1:0]       sts_wr,
  output logic [NUM_LINKS-1:0]       en_wr,
  output logic [REG_W-1:0]           rsp_rdata,
  output logic                       rsp_valid
);
  logic [REG_W-1:0] rd_mux;

  always_comb begin
    for (int l = 0; l < NUM_LINKS; l++) begin
      sts_wr[l] = req_wr && (req_addr == ADDR_W'(STS_BASE) + ADDR_W'(l));
      en_wr[l]  = req_wr && (req_addr == ADDR_W'(EN_BASE)  + ADDR_W'(l));
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int l = 0; l < NUM_LINKS; l++) begin
      if (req_addr == ADDR_W'(STS_BASE) + ADDR_W'(l)) rd_mux = sts_flat[l*REG_W +: REG_W];
      if (req_addr == ADDR_W'(EN_BASE)  + ADDR_W'(l)) rd_mux = en_flat[l*REG_W +: REG_W];
    end
    if (req_addr == ADDR_W'(GRP_ADDR)) rd_mux = grp_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= req_rd;
      if (req_rd) rsp_rdata <= rd_mux;
    end
  end

  // R10: every read is answered in the next cycle, and only then
  assert_rsp_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> rsp_valid);
  assert_rsp_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> !rsp_valid);
  // at most one register decoded per write
  assert_wr_decode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sts_wr, en_wr}));
endmodule

// File: rtl/link_irq_ctrl.sv
module link_irq_ctrl
  import lic_pkg::*;
#(
  parameter int          NUM_LINKS  = 4,
  parameter int          NUM_GROUPS = 4,
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] STS_BASE   = 12'h222,
  parameter logic [11:0] EN_BASE    = 12'h219,
  parameter logic [11:0] GRP_ADDR   = 12'h235
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_wr,
  input  logic                  req_rd,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [7:0]            req_wdata,
  output logic [7:0]            rsp_rdata,
  output logic                  rsp_valid,
  input  logic [NUM_LINKS-1:0]  lnk_icp_chg,
  input  logic [NUM_LINKS-1:0]  lnk_icp_viol,
  input  logic [NUM_LINKS-1:0]  lnk_lods,
  input  logic [NUM_LINKS-1:0]  lnk_lif,
  input  logic [NUM_LINKS-1:0]  lnk_lcd,
  input  logic [NUM_LINKS-1:0]  lnk_cnt_ovf,
  input  logic [NUM_LINKS-1:0]  lnk_cnt_svc,
  input  logic [NUM_GROUPS-1:0] grp_tx_done,
  input  logic [NUM_GROUPS-1:0] grp_frame,
  input  logic [NUM_GROUPS-1:0] grp_ovf_set,
  input  logic [NUM_GROUPS-1:0] grp_ovf_svc,
  output logic                  irq
);
  localparam int FLAT_W = NUM_LINKS * REG_W;

  logic [FLAT_W-1:0]    sts_flat;
  logic [FLAT_W-1:0]    en_flat;
  logic [NUM_LINKS-1:0] sts_wr;
  logic [NUM_LINKS-1:0] en_wr;
  logic [NUM_LINKS-1:0] link_hit;
  logic [REG_W-1:0]     grp_byte;
  logic                 grp_any;
  logic                 tx_any;

  assign tx_any = |(grp_tx_done | grp_frame);

  lic_grp_ovf #(.NUM_GROUPS(NUM_GROUPS)) u_grp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovf_set  (grp_ovf_set),
    .ovf_svc  (grp_ovf_svc),
    .grp_byte (grp_byte),
    .any_ovf  (grp_any)
  );

  lic_reg_port #(
    .NUM_LINKS (NUM_LINKS),
    .ADDR_W    (ADDR_W),
    .STS_BASE  (STS_BASE),
    .EN_BASE   (EN_BASE),
    .GRP_ADDR  (GRP_ADDR)
  ) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_wr    (req_wr),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .sts_flat  (sts_flat),
    .en_flat   (en_flat),
    .grp_byte  (grp_byte),
    .sts_wr    (sts_wr),
    .en_wr     (en_wr),
    .rsp_rdata (rsp_rdata),
    .rsp_valid (rsp_valid)
  );

  genvar l;
  generate
    for (l = 0; l < NUM_LINKS; l++) begin : g_link
      link_evt_t ev;
      assign ev.icp_chg  = lnk_icp_chg[l];
      assign ev.icp_viol = lnk_icp_viol[l];
      assign ev.lods     = lnk_lods[l];
      assign ev.lif      = lnk_lif[l];
      assign ev.lcd      = lnk_lcd[l];

      lic_link_reg #(.HAS_SUMMARY(l == 0)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (ev),
        .tx_evt  (tx_any),
        .grp_any (grp_any),
        .cnt_set (lnk_cnt_ovf[l]),
        .cnt_svc (lnk_cnt_svc[l]),
        .sts_wr  (sts_wr[l]),
        .en_wr   (en_wr[l]),
        .wdata   (req_wdata),
        .sts     (sts_flat[l*REG_W +: REG_W]),
        .en      (en_flat[l*REG_W +: REG_W])
      );

      assign link_hit[l] = |(sts_flat[l*REG_W +: REG_W] & en_flat[l*REG_W +: REG_W]);
    end
  endgenerate

  assign irq = |link_hit;

  // R9: interrupt requires some enable bit to be set
  assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|en_flat));
  // R6: link 0 bit 7 tracks the group summary register
  assert_govf_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_flat[B_GOVF] == (|grp_byte));
  // R1: all state is clear right after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (sts_flat == '0 && en_flat == '0 && !irq));
endmodule

// File: tb/tb_link_irq_ctrl.sv
module tb_link_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 0, req_rd = 0;
  logic [11:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rsp_rdata;
  logic        rsp_valid;
  logic [3:0]  lnk_icp_chg = 0, lnk_icp_viol = 0, lnk_lods = 0, lnk_lif = 0, lnk_lcd = 0;
  logic [3:0]  lnk_cnt_ovf = 0, lnk_cnt_svc = 0;
  logic [3:0]  grp_tx_done = 0, grp_frame = 0, grp_ovf_set = 0, grp_ovf_svc = 0;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  link_irq_ctrl dut (.*);

  localparam logic [11:0] STS0 = 12'h222, EN0 = 12'h219, GRP = 12'h235;

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R10 unexpected response actual=%02h expected=none", rsp_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          failures++;
          $display("FAIL %s actual=%02h expected=%02h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req_rd = 1; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_rd = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    req_wr = 1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_wr = 0;
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R8 reset values
    for (int l = 0; l < 4; l++) begin
      rd(STS0 + 12'(l), 8'h00, "R1 status reset");
      rd(EN0 + 12'(l), 8'h00, "R1 R8 enable reset");
    end
    rd(GRP, 8'h00, "R1 group reset");
    chk_irq(1'b0, "R1");

    // R2 sticky event, masked interrupt
    lnk_lods[2] = 1; tick(); lnk_lods[2] = 0;
    tick();
    rd(STS0 + 2, 8'h08, "R2 lods sticky");
    chk_irq(1'b0, "R9 masked");
    wr(EN0 + 2, 8'h08);
    rd(EN0 + 2, 8'h08, "R8 enable readback");
    chk_irq(1'b1, "R9 enabled");
    wr(STS0 + 2, 8'hFF);
    rd(STS0 + 2, 8'h08, "R2 write one no effect");
    wr(STS0 + 2, 8'hF7);
    rd(STS0 + 2, 8'h00, "R2 write zero clears");
    chk_irq(1'b0, "R9 cleared");
    lnk_icp_chg[3] = 1; lnk_icp_viol[3] = 1; lnk_lcd[3] = 1; tick();
    lnk_icp_chg[3] = 0; lnk_icp_viol[3] = 0; lnk_lcd[3] = 0;
    rd(STS0 + 3, 8'h32, "R2 several bits");
    wr(STS0 + 3, 8'hEF);
    rd(STS0 + 3, 8'h22, "R2 partial clear");
    wr(STS0 + 3, 8'h00);
    wr(EN0 + 1, 8'hA5);
    rd(EN0 + 1, 8'hA5, "R8 full byte");
    wr(EN0 + 1, 8'h00);

    // R3 counter overflow bit
    lnk_cnt_ovf[1] = 1; tick(); lnk_cnt_ovf[1] = 0;
    wr(STS0 + 1, 8'h00);
    rd(STS0 + 1, 8'h01, "R3 write ignored");
    lnk_cnt_svc[1] = 1; tick(); lnk_cnt_svc[1] = 0;
    rd(STS0 + 1, 8'h00, "R3 serviced");

    // R4 transmit/frame summary bit
    grp_tx_done[2] = 1; tick(); grp_tx_done[2] = 0;
    rd(STS0, 8'h40, "R4 tx done sets link0 bit6");
    rd(STS0 + 1, 8'h00, "R4 link1 no summary");
    wr(STS0, 8'hBF);
    rd(STS0, 8'h00, "R4 bit6 write zero clears");
    grp_frame[0] = 1; tick(); grp_frame[0] = 0;
    rd(STS0, 8'h40, "R4 frame pulse sets bit6");
    wr(STS0, 8'h00);

    // R5 / R6 group overflow
    grp_ovf_set[3] = 1; tick(); grp_ovf_set[3] = 0;
    rd(GRP, 8'h08, "R5 group bit set");
    rd(STS0, 8'h80, "R6 link0 bit7");
    rd(STS0 + 3, 8'h00, "R4 link3 no summary");
    wr(GRP, 8'h00);
    rd(GRP, 8'h08, "R5 write zero ignored");
    wr(GRP, 8'hFF);
    rd(GRP, 8'h08, "R5 write one ignored reserved zero");
    wr(STS0, 8'h00);
    rd(STS0, 8'h80, "R6 bit7 ignores write");
    wr(EN0, 8'h80);
    chk_irq(1'b1, "R9 via group summary");
    grp_ovf_svc[3] = 1; tick(); grp_ovf_svc[3] = 0;
    rd(GRP, 8'h00, "R5 serviced");
    rd(STS0, 8'h00, "R6 bit7 follows");
    chk_irq(1'b0, "R9 after service");
    wr(EN0, 8'h00);

    // R7 set beats clear
    lnk_lif[3] = 1; req_wr = 1; req_addr = STS0 + 3; req_wdata = 8'h00;
    tick();
    lnk_lif[3] = 0; req_wr = 0;
    rd(STS0 + 3, 8'h04, "R7 event beats zero-write");
    lnk_cnt_ovf[0] = 1; lnk_cnt_svc[0] = 1; tick();
    lnk_cnt_ovf[0] = 0; lnk_cnt_svc[0] = 0;
    rd(STS0, 8'h01, "R7 overflow beats service");
    grp_ovf_set[1] = 1; grp_ovf_svc[1] = 1; tick();
    grp_ovf_set[1] = 0; grp_ovf_svc[1] = 0;
    rd(GRP, 8'h02, "R7 group set beats service");

    // R10 unmapped address
    rd(12'h230, 8'h00, "R10 unmapped reads zero");
    rd(12'h000, 8'h00, "R10 unmapped low");

    tick();
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R10 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule